// File: doc/BRIEF.md
# Phase-Frequency Detector with Antibacklash Overlap and Lock Indicator

This block compares two single-cycle edge strobes, one from the divided reference and one from the divided feedback, and drives a pair of pump-control outputs. Both strobes are sampled by a fast clock. A reference edge that arrives first raises `pump_up`. A feedback edge that arrives first raises `pump_dn`. The width of the one-sided pulse carries both the phase error and the frequency error between the two inputs. When the lagging edge arrives, both outputs are held high together for a programmable number of sampling-clock cycles, and then the detector returns to rest. Every comparison therefore produces a pulse of at least a minimum width, which removes the dead zone near zero phase error.

The detector is a four-state machine. The states are IDLE (both outputs low), UP_ACT (only `pump_up` high), DN_ACT (only `pump_dn` high) and OVERLAP (both outputs high while the antibacklash timer runs). The transitions are:
- IDLE→UP_ACT on a reference strobe alone.
- IDLE→DN_ACT on a feedback strobe alone.
- IDLE→OVERLAP when both strobes come in the same cycle.
- UP_ACT→OVERLAP on a feedback strobe.
- DN_ACT→OVERLAP on a reference strobe.
- OVERLAP→IDLE when the timer expires.
- Any state→IDLE when power-down is asserted.

A lock indicator, `lock_o`, sits high and drops low only in the cycles where exactly one output is active. When the loop is locked, this appears as narrow low-going pulses. Power-down holds `lock_o` low.

Top module: `pfd_abl_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `pump_up` and `pump_dn` are 0 and `lock_o` is 1.
- R2: In IDLE, a lone `ref_stb` makes `pump_up` high and `pump_dn` low from the next cycle on. A lone `fb_stb` does the mirror of this.
- R3: In UP_ACT, a repeated `ref_stb` has no effect and the state is held until `fb_stb` arrives. In DN_ACT, a repeated `fb_stb` has no effect and the state is held until `ref_stb` arrives.
- R4: A strobe on the opposite input during a one-sided state makes both outputs high from the next cycle on.
- R5: When `ref_stb` and `fb_stb` are both high in the same IDLE cycle, both outputs go high together on the next cycle, with no one-sided cycle.
- R6: Both outputs stay high together for exactly L = max(`abl_cycles`, 1) cycles and then both go low. If the lagging edge comes d cycles after the leading one, the leading output is high for d + L cycles and the lagging output for L cycles.
- R7: Strobes on either input while both outputs are high are ignored.
- R8: `lock_o` is 0 in exactly the cycles where one output is high and the other is low. Outside power-down it is 1 in every other cycle.
- R9: In the cycle after `pwr_dn` is sampled high, both outputs and the timer are cleared and `lock_o` is 0. Strobes are ignored while `pwr_dn` is high. `lock_o` returns to 1 one cycle after `pwr_dn` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | 1 | Synchronous power-down |
| ref_stb | input | 1 | One-cycle strobe from the divided reference |
| fb_stb | input | 1 | One-cycle strobe from the divided feedback |
| abl_cycles | input | ABL_W | Antibacklash overlap length in clock cycles; 0 is treated as 1 |
| pump_up | output | 1 | Pump-up control |
| pump_dn | output | 1 | Pump-down control |
| lock_o | output | 1 | Lock indicator, low during one-sided activity |

## Verification
The overlap-width property assumes that `abl_cycles` does not change while both outputs are high. The stimulus changes `abl_cycles` only when the detector is in IDLE, between comparisons. The properties also treat each strobe as an edge event and do not require that strobes on the same input be spaced apart. The stimulus exploits this on purpose: it repeats the leading strobe and fires both strobes again during OVERLAP, so that the ignore paths are exercised. Every other case keeps to one leading edge and one lagging edge per comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2,
        PFD_OVL  = 2'd3
    } pfd_state_e;

endpackage

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] span,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_idx;

    // A span of zero behaves as a span of one: the final index is 0 in both cases.
    always_comb begin
        if (span == CNT_ZERO) begin
            last_idx = CNT_ZERO;
        end else begin
            last_idx = span - CNT_ONE;
        end
    end

    assign expire = run && (cnt_q == last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else if (clr || !run || expire) begin
            cnt_q <= CNT_ZERO;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn,
    input  logic       ref_stb,
    input  logic       fb_stb,
    input  logic       expire,
    output pfd_state_e state,
    output logic       up,
    output logic       dn
);
    pfd_state_e state_q;
    pfd_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PFD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFD_IDLE: begin
                if (ref_stb && fb_stb) begin
                    state_d = PFD_OVL;
                end else if (ref_stb) begin
                    state_d = PFD_UP;
                end else if (fb_stb) begin
                    state_d = PFD_DN;
                end
            end
            PFD_UP: begin
                if (fb_stb) begin
                    state_d = PFD_OVL;
                end
            end
            PFD_DN: begin
                if (ref_stb) begin
                    state_d = PFD_OVL;
                end
            end
            PFD_OVL: begin
                if (expire) begin
                    state_d = PFD_IDLE;
                end
            end
        endcase
        if (pwr_dn) begin
            state_d = PFD_IDLE;
        end
    end

    // Output decode
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state_q)
            PFD_IDLE: begin
                up = 1'b0;
                dn = 1'b0;
            end
            PFD_UP: begin
                up = 1'b1;
                dn = 1'b0;
            end
            PFD_DN: begin
                up = 1'b0;
                dn = 1'b1;
            end
            PFD_OVL: begin
                up = 1'b1;
                dn = 1'b1;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pfd_lock_ind.sv
module pfd_lock_ind (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic up,
    input  logic dn,
    output logic lock
);
    logic pd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= 1'b0;
        end else begin
            pd_q <= pwr_dn;
        end
    end

    // One-sided activity is the excess beyond the forced overlap.
    assign lock = !pd_q && !(up ^ dn);

endmodule

// File: rtl/pfd_abl_detect.sv
module pfd_abl_detect
    import pfd_pkg::*;
#(
    parameter int ABL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             ref_stb,
    input  logic             fb_stb,
    input  logic [ABL_W-1:0] abl_cycles,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             lock_o
);
    pfd_state_e state;
    logic       expire;
    logic       ovl_run;

    assign ovl_run = (state == PFD_OVL);

    pfd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_dn  (pwr_dn),
        .ref_stb (ref_stb),
        .fb_stb  (fb_stb),
        .expire  (expire),
        .state   (state),
        .up      (pump_up),
        .dn      (pump_dn)
    );

    pfd_abl_timer #(.CNT_W(ABL_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pwr_dn),
        .run    (ovl_run),
        .span   (abl_cycles),
        .expire (expire)
    );

    pfd_lock_ind u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_dn (pwr_dn),
        .up     (pump_up),
        .dn     (pump_dn),
        .lock   (lock_o)
    );

endmodule

// File: rtl/pfd_abl_detect_chk.sv
module pfd_abl_detect_chk #(
    parameter int ABL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic             ref_stb,
    input logic             fb_stb,
    input logic [ABL_W-1:0] abl_cycles,
    input logic             pump_up,
    input logic             pump_dn,
    input logic             lock_o
);
    localparam int LEN_W = ABL_W + 1;

    logic [LEN_W-1:0] ovl_len;
    logic [LEN_W-1:0] ovl_lim;

    assign ovl_lim = (abl_cycles == '0) ? LEN_W'(1) : {1'b0, abl_cycles};

    // Length of the current run of cycles in which both outputs are high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_len <= '0;
        end else if (pump_up && pump_dn) begin
            ovl_len <= ovl_len + LEN_W'(1);
        end else begin
            ovl_len <= '0;
        end
    end

    AST_RST_QUIET: assert property (@(posedge clk)
        !$past(rst_n) |-> (!pump_up && !pump_dn && lock_o)); // R1

    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && !pump_dn && !fb_stb && !pwr_dn) |=> (pump_up && !pump_dn)); // R3

    AST_DN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_dn && !pump_up && !ref_stb && !pwr_dn) |=> (pump_dn && !pump_up)); // R3

    AST_DIRECT_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up && !pump_dn && ref_stb && fb_stb && !pwr_dn) |=> (pump_up && pump_dn)); // R5

    AST_OVERLAP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_len != '0 && !(pump_up && pump_dn) && !$past(pwr_dn)) |-> (ovl_len == ovl_lim)); // R6

    AST_LOCK_LOW_ONE_SIDED: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up != pump_dn) |-> !lock_o); // R8

    AST_LOCK_HIGH_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pump_up == pump_dn) && $past(rst_n) && !$past(pwr_dn)) |-> lock_o); // R8

    AST_PWR_DN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pwr_dn)) |-> (!pump_up && !pump_dn && !lock_o)); // R9

endmodule

bind pfd_abl_detect pfd_abl_detect_chk #(.ABL_W(ABL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .ref_stb    (ref_stb),
    .fb_stb     (fb_stb),
    .abl_cycles (abl_cycles),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .lock_o     (lock_o)
);

// File: tb/pfd_abl_detect_tb.sv
`timescale 1ns/1ps
module pfd_abl_detect_tb;
    localparam int ABL_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_dn = 1'b0;
    logic             ref_stb = 1'b0;
    logic             fb_stb = 1'b0;
    logic [ABL_W-1:0] abl_cycles = '0;
    logic             pump_up;
    logic             pump_dn;
    logic             lock_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pfd_abl_detect #(.ABL_W(ABL_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .ref_stb    (ref_stb),
        .fb_stb     (fb_stb),
        .abl_cycles (abl_cycles),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn),
        .lock_o     (lock_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One comparison: leading strobe at step 0 and lagging strobe at step d.
    // The counts of high cycles are checked against the formula in R6.
    task automatic run_case(input int d, input int l, input bit ref_first, input bit noise);
        int upc = 0;
        int dnc = 0;
        int both = 0;
        int low = 0;
        int lm = (l == 0) ? 1 : l;
        int exp_up = (ref_first ? d : 0) + lm;
        int exp_dn = (ref_first ? 0 : d) + lm;
        abl_cycles = ABL_W'(l);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (pump_up) upc++;
                if (pump_dn) dnc++;
                if (pump_up && pump_dn) both++;
                if (!lock_o) low++;
            end
            ref_stb = 1'b0;
            fb_stb  = 1'b0;
            if (i == 0) begin
                if (ref_first || d == 0) ref_stb = 1'b1;
                if (!ref_first || d == 0) fb_stb = 1'b1;
            end
            if (d > 0 && i == d) begin
                if (ref_first) fb_stb = 1'b1;
                else ref_stb = 1'b1;
            end
            if (noise && d >= 2 && i == 1) begin
                if (ref_first) ref_stb = 1'b1;
                else fb_stb = 1'b1;
            end
            if (noise && i == d + 1) begin
                ref_stb = 1'b1;
                fb_stb  = 1'b1;
            end
        end
        chk(upc == exp_up, noise ? "R3 up width" : "R2 up width", upc, exp_up);
        chk(dnc == exp_dn, noise ? "R7 dn width" : "R6 dn width", dnc, exp_dn);
        chk(both == lm, (d == 0) ? "R5 overlap width" : "R4 overlap width", both, lm);
        chk(low == d, "R8 lock low cycles", low, d);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!pump_up && !pump_dn, "R1 outputs in reset", {pump_up, pump_dn}, 0);
        chk(lock_o == 1'b1, "R1 lock in reset", lock_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pump_up && !pump_dn, "R1 outputs after reset", {pump_up, pump_dn}, 0);
        chk(lock_o == 1'b1, "R1 lock after reset", lock_o, 1);

        // R2/R3/R4/R5/R6/R7/R8: sweep of lag, overlap length, order and extra strobes
        for (int d = 0; d < 7; d++) begin
            for (int l = 0; l < 5; l++) begin
                for (int o = 0; o < 2; o++) begin
                    for (int n = 0; n < 2; n++) begin
                        run_case(d, l, o[0], n[0]);
                    end
                end
            end
        end

        // R9: power-down during a one-sided pulse
        abl_cycles = ABL_W'(3);
        @(negedge clk);
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        chk(pump_up && !lock_o, "R9 pre up active", {pump_up, lock_o}, 2);
        @(negedge clk);
        pwr_dn = 1'b1;
        @(negedge clk);
        chk(!pump_up && !pump_dn, "R9 outputs cleared", {pump_up, pump_dn}, 0);
        chk(lock_o == 1'b0, "R9 lock held low", lock_o, 0);
        ref_stb = 1'b1;
        fb_stb  = 1'b1;
        @(negedge clk);
        chk(!pump_up && !pump_dn, "R9 strobes ignored", {pump_up, pump_dn}, 0);
        ref_stb = 1'b0;
        fb_stb  = 1'b0;
        pwr_dn  = 1'b0;
        @(negedge clk);
        chk(lock_o == 1'b1, "R9 lock restored", lock_o, 1);
        chk(!pump_up && !pump_dn, "R9 idle after release", {pump_up, pump_dn}, 0);

        // R9: power-down in the middle of an overlap, then a normal comparison
        ref_stb = 1'b1;
        fb_stb  = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        fb_stb  = 1'b0;
        pwr_dn  = 1'b1;
        @(negedge clk);
        chk(!pump_up && !pump_dn, "R9 overlap cut", {pump_up, pump_dn}, 0);
        pwr_dn = 1'b0;
        @(negedge clk);
        run_case(3, 2, 1'b0, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule